// File: doc/BRIEF.md
# Switchable-Depth Queue with Fill-Level Interrupt

This block is a small first-in first-out queue that sits on either side of a serial link: on the transmit side it holds bytes waiting to be shifted out, and on the receive side it holds received words together with their error bits. A single enable input picks between two operating depths. When the enable is low the queue behaves as a one-word holding register. When it is high the queue uses its full depth of 16 words. Any change of that enable empties the queue.

The block reports empty and full, and raises a one-cycle overrun pulse when a word is offered while no room is left. It also raises a level-sensitive interrupt request that compares the fill count against a threshold chosen in eighths of the depth. A direction parameter sets the sense of that comparison. On the receive side the request means "enough words are waiting". On the transmit side it means "room is running low". Register access, interrupt masking and interrupt clearing are handled outside this block.

Top module: `level_fifo`

## Requirements
- R1: After reset the queue is empty and disabled: `empty`=1, `full`=0, `overrun`=0. The receive-side `irq` is 0 and the transmit-side `irq` is 1.
- R2: With `fifo_en` low the queue holds at most one word. `full` rises as soon as that word is stored, and a second push is dropped.
- R3: With `fifo_en` high the queue holds up to `DEPTH` (16) words in arrival order. `full` is 1 exactly when 16 words are held, and `empty` is 1 exactly when none are held.
- R4: `pop_data` always shows the oldest stored word. A pop while empty has no effect.
- R5: A push while full is dropped and leaves the stored words unchanged. `overrun` is high for exactly the one cycle after that push edge. A pop in the same cycle is still performed.
- R6: A clock edge at which `fifo_en` differs from the current mode switches the mode and leaves the queue empty. A push or pop offered in that cycle is ignored.
- R7: The threshold is selected by `lvl_sel`: code 0 gives 2 words (1/8), 1 gives 4 (1/4), 2 gives 8 (1/2), 3 gives 12 (3/4), and 4 gives 14 (7/8). Codes 5, 6 and 7 fall back to 8, the mid-point.
- R8: On the receive side (`IS_RX`=1), in full-depth mode, `irq` is 1 while the fill count is at or above the threshold. In holding mode it is 1 while a word is held.
- R9: On the transmit side (`IS_RX`=0), in full-depth mode, `irq` is 1 while the fill count is at or below the threshold. In holding mode it is 1 while the queue is empty.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full keep the count unchanged and preserve order. On an empty queue the pop is ignored and the push is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects full depth, 0 selects one-word holding mode |
| lvl_sel | input | 3 | Interrupt threshold code |
| push | input | 1 | Store `push_data` at this edge if there is room |
| push_data | input | DW | Word to store |
| pop | input | 1 | Remove the oldest word at this edge if one is held |
| pop_data | output | DW | Oldest stored word |
| empty | output | 1 | No word held |
| full | output | 1 | Capacity of the current mode reached |
| overrun | output | 1 | One-cycle pulse after a dropped push |
| irq | output | 1 | Fill-level interrupt request |

## Verification
The bench builds two copies side by side from the same stimulus. The first uses `DW`=12 and `IS_RX`=1, the second `DW`=8 and `IS_RX`=0, both at the default depth of 16. The pairing shows both comparison senses of the interrupt at every fill count from 0 to 16 and for all eight select codes, including the three fallback codes. The two data widths confirm that the stored words keep their upper bits on the wide copy.

// File: rtl/lf_pkg.sv
package lf_pkg;

    // Threshold in words for a level code, as eighths of the depth.
    function automatic int unsigned lf_threshold(input logic [2:0] code,
                                                 input int unsigned depth);
        case (code)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd3:    return (depth * 3) / 4;
            3'd4:    return (depth * 7) / 8;
            default: return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/lf_ctrl.sv
module lf_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push,
    input  logic          pop,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] rd_idx,
    output logic [CW-1:0] fill,
    output logic          mode,
    output logic          empty,
    output logic          full,
    output logic          overrun
);

    typedef struct packed {
        logic          mode;
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          ovr;
    } ctrl_t;

    localparam logic [CW-1:0] FULL_CAP = CW'(DEPTH);
    localparam logic [CW-1:0] HOLD_CAP = CW'(1);

    ctrl_t s_d, s_q;
    logic  full_c, empty_c, do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        s_d.ovr = 1'b0;
        wr_en   = 1'b0;
        do_push = 1'b0;
        do_pop  = 1'b0;
        empty_c = (s_q.count == '0);
        full_c  = (s_q.count == (s_q.mode ? FULL_CAP : HOLD_CAP));

        if (fifo_en != s_q.mode) begin
            // mode change: empty the queue, ignore this cycle's traffic
            s_d.mode   = fifo_en;
            s_d.wr_ptr = '0;
            s_d.rd_ptr = '0;
            s_d.count  = '0;
        end else begin
            do_push = push && !full_c;
            do_pop  = pop && !empty_c;
            s_d.ovr = push && full_c;
            wr_en   = do_push;
            if (do_push && s_q.mode) s_d.wr_ptr = s_q.wr_ptr + AW'(1);
            if (do_pop && s_q.mode)  s_d.rd_ptr = s_q.rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   s_d.count = s_q.count + CW'(1);
                2'b01:   s_d.count = s_q.count - CW'(1);
                default: s_d.count = s_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_idx  = s_q.wr_ptr;
    assign rd_idx  = s_q.rd_ptr;
    assign fill    = s_q.count;
    assign mode    = s_q.mode;
    assign empty   = (s_q.count == '0);
    assign full    = (s_q.count == (s_q.mode ? FULL_CAP : HOLD_CAP));
    assign overrun = s_q.ovr;

endmodule

// File: rtl/lf_store.sv
module lf_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] cell_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [DW-1:0] cell_d;
        always_comb begin
            cell_d = cell_q[i];
            if (wr_en && (wr_idx == AW'(i))) cell_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q[i] <= '0;
            else        cell_q[i] <= cell_d;
        end
    end

    assign rd_data = cell_q[rd_idx];

endmodule

// File: rtl/lf_level.sv
module lf_level #(
    parameter int DEPTH = 16,
    parameter bit IS_RX = 1'b0,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] fill,
    input  logic          mode,
    input  logic [2:0]    lvl_sel,
    output logic          irq
);
    import lf_pkg::*;

    logic [CW-1:0] thr;

    always_comb thr = CW'(lf_threshold(lvl_sel, DEPTH));

    if (IS_RX) begin : g_rx
        always_comb irq = mode ? (fill >= thr) : (fill != '0);
    end else begin : g_tx
        always_comb irq = mode ? (fill <= thr) : (fill == '0);
    end

endmodule

// File: rtl/level_fifo.sv
module level_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter bit IS_RX = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [2:0]    lvl_sel,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          empty,
    output logic          full,
    output logic          overrun,
    output logic          irq
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_en;
    logic [AW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] fill_q;
    logic          mode_q;

    lf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push(push), .pop(pop),
        .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx), .fill(fill_q),
        .mode(mode_q), .empty(empty), .full(full), .overrun(overrun)
    );

    lf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(push_data), .rd_idx(rd_idx), .rd_data(pop_data)
    );

    lf_level #(.DEPTH(DEPTH), .IS_RX(IS_RX)) u_level (
        .fill(fill_q), .mode(mode_q), .lvl_sel(lvl_sel), .irq(irq)
    );

endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5,
    parameter bit IS_RX = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          push,
    input logic          pop,
    input logic          empty,
    input logic          full,
    input logic          overrun,
    input logic          irq,
    input logic          mode_q,
    input logic [CW-1:0] fill_q
);
    localparam logic [CW-1:0] CAP   = CW'(DEPTH);
    localparam logic [CW-1:0] LOW8  = CW'(DEPTH / 8);
    localparam logic [CW-1:0] HIGH8 = CW'((DEPTH * 7) / 8);

    logic steady;
    assign steady = (fifo_en == mode_q);

    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= (mode_q ? CAP : CW'(1)));

    p_hold_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !empty) |-> full);

    p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push && steady) |=> empty);

    p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && steady) |=> overrun);

    p_no_spurious_ovr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full) |=> !overrun);

    p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && steady) |=> (full && $stable(fill_q)));

    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !steady |=> (empty && mode_q == $past(fifo_en)));

    p_both_ways_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !full && steady) |=> $stable(fill_q));

    if (IS_RX) begin : g_rx
        p_rx_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q && fill_q >= HIGH8) |-> irq);
        p_rx_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_q < LOW8) && mode_q |-> !irq);
    end else begin : g_tx
        p_tx_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q && fill_q <= LOW8) |-> irq);
        p_tx_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q && fill_q > HIGH8) |-> !irq);
    end

endmodule

bind level_fifo lf_checker #(.DEPTH(DEPTH), .CW(CW), .IS_RX(IS_RX)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push(push), .pop(pop),
    .empty(empty), .full(full), .overrun(overrun), .irq(irq),
    .mode_q(mode_q), .fill_q(fill_q)
);

// File: tb/tb_level_fifo.sv
`timescale 1ns/1ps
module tb_level_fifo;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic [2:0]  lvl = 3'd2;
    logic        push = 1'b0, pop = 1'b0;
    logic [11:0] wdata = '0;

    logic [11:0] rx_data;
    logic [7:0]  tx_data;
    logic        rx_empty, rx_full, rx_ovr, rx_irq;
    logic        tx_empty, tx_full, tx_ovr, tx_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    level_fifo #(.DW(12), .DEPTH(DEPTH), .IS_RX(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .lvl_sel(lvl),
        .push(push), .push_data(wdata), .pop(pop), .pop_data(rx_data),
        .empty(rx_empty), .full(rx_full), .overrun(rx_ovr), .irq(rx_irq)
    );

    level_fifo #(.DW(8), .DEPTH(DEPTH), .IS_RX(1'b0)) dut_tx (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .lvl_sel(lvl),
        .push(push), .push_data(wdata[7:0]), .pop(pop), .pop_data(tx_data),
        .empty(tx_empty), .full(tx_full), .overrun(tx_ovr), .irq(tx_irq)
    );

    typedef struct packed {
        logic        en;
        logic        psh;
        logic        pp;
        logic [11:0] d;
        logic        e_empty;
        logic        e_full;
        logic        e_ovr;
        logic        e_rx;
        logic        e_tx;
        logic [11:0] e_head;
    } vec_t;

    // lvl_sel stays at code 2 while the table runs
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 12'h0A1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h0A1}, // R2 store one
        '{1'b0, 1'b1, 1'b0, 12'h0B2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 12'h0A1}, // R2/R5 drop
        '{1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h0A1}, // R5 pulse ends
        '{1'b0, 1'b0, 1'b1, 12'h000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000}, // R4 pop
        '{1'b0, 1'b0, 1'b1, 12'h000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000}, // R4 pop empty
        '{1'b0, 1'b1, 1'b1, 12'h0C3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h0C3}, // R10 empty both
        '{1'b1, 1'b1, 1'b0, 12'h0D4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000}, // R6 flush
        '{1'b1, 1'b1, 1'b0, 12'h111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'h111}, // R3
        '{1'b1, 1'b1, 1'b1, 12'h222, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'h222}, // R10
        '{1'b0, 1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000}, // R6 back
        '{1'b1, 1'b0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000}  // R6 again
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one clock with the given controls; outputs are sampled 1 ns after the edge
    task automatic step(input logic en, input logic ps, input logic pp, input logic [11:0] d);
        fifo_en = en; push = ps; pop = pp; wdata = d;
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0;
    endtask

    function automatic int thr_of(input int code);
        case (code)
            0: return 2;
            1: return 4;
            3: return 12;
            4: return 14;
            default: return 8;
        endcase
    endfunction

    task automatic level_sweep(input int cnt);
        for (int c = 0; c < 8; c++) begin
            lvl = 3'(c);
            #0.1;
            check("R7/R8 rx irq", 32'(rx_irq), 32'(cnt >= thr_of(c)));
            check("R7/R9 tx irq", 32'(tx_irq), 32'(cnt <= thr_of(c)));
        end
        lvl = 3'd2;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 empty", 32'(rx_empty & tx_empty), 32'd1);
        check("R1 full", 32'(rx_full | tx_full), 32'd0);
        check("R1 overrun", 32'(rx_ovr | tx_ovr), 32'd0);
        check("R1 rx irq", 32'(rx_irq), 32'd0);
        check("R1 tx irq", 32'(tx_irq), 32'd1);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].en, VECS[i].psh, VECS[i].pp, VECS[i].d);
            check($sformatf("table %0d empty", i), 32'({rx_empty, tx_empty}), 32'({2{VECS[i].e_empty}}));
            check($sformatf("table %0d full", i), 32'({rx_full, tx_full}), 32'({2{VECS[i].e_full}}));
            check($sformatf("table %0d overrun", i), 32'({rx_ovr, tx_ovr}), 32'({2{VECS[i].e_ovr}}));
            check($sformatf("table %0d rx irq", i), 32'(rx_irq), 32'(VECS[i].e_rx));
            check($sformatf("table %0d tx irq", i), 32'(tx_irq), 32'(VECS[i].e_tx));
            if (!VECS[i].e_empty) begin
                check($sformatf("table %0d rx head", i), 32'(rx_data), 32'(VECS[i].e_head));
                check($sformatf("table %0d tx head", i), 32'(tx_data), 32'(VECS[i].e_head[7:0]));
            end
        end

        // R3/R7/R8/R9: fill to 16 in full-depth mode, sweep every code at every count
        level_sweep(0);
        for (int k = 0; k < DEPTH; k++) begin
            step(1'b1, 1'b1, 1'b0, 12'h300 + 12'(k));
            check("R3 full flag", 32'({rx_full, tx_full}), 32'({2{k == DEPTH - 1}}));
            check("R3 empty flag", 32'({rx_empty, tx_empty}), 32'd0);
            check("R4 head oldest", 32'(rx_data), 32'h300);
            level_sweep(k + 1);
        end

        // R5: push while full
        step(1'b1, 1'b1, 1'b0, 12'hFFF);
        check("R5 overrun pulse", 32'({rx_ovr, tx_ovr}), 32'h3);
        check("R5 still full", 32'({rx_full, tx_full}), 32'h3);
        step(1'b1, 1'b0, 1'b0, 12'h000);
        check("R5 pulse one cycle", 32'({rx_ovr, tx_ovr}), 32'h0);

        // R5: push and pop together while full
        step(1'b1, 1'b1, 1'b1, 12'hEEE);
        check("R5 overrun with pop", 32'(rx_ovr), 32'd1);
        check("R5 pop done", 32'(rx_full), 32'd0);

        // R3/R5 drain: order kept, dropped words absent
        for (int k = 1; k < DEPTH; k++) begin
            check("R3 order rx", 32'(rx_data), 32'h300 + 32'(k));
            check("R3 order tx", 32'(tx_data), 32'(8'(8'h00 + 8'(k))));
            step(1'b1, 1'b0, 1'b1, 12'h000);
        end
        check("R3 drained", 32'({rx_empty, tx_empty}), 32'h3);

        // R4 pop on empty
        step(1'b1, 1'b0, 1'b1, 12'h000);
        check("R4 empty pop", 32'({rx_empty, rx_ovr}), 32'h2);
        step(1'b1, 1'b1, 1'b0, 12'h455);
        check("R4 head", 32'(rx_data), 32'h455);

        // R10 push and pop with one word held
        step(1'b1, 1'b1, 1'b1, 12'h466);
        check("R10 head moves", 32'(rx_data), 32'h466);
        check("R10 count kept", 32'({rx_empty, rx_full}), 32'h0);

        // R6: switching to holding mode drops the held word and ignores the push
        step(1'b0, 1'b1, 1'b0, 12'h477);
        check("R6 flushed", 32'({rx_empty, tx_empty}), 32'h3);
        step(1'b0, 1'b1, 1'b0, 12'h588);
        check("R2 holding full", 32'({rx_full, tx_full}), 32'h3);
        check("R2 head", 32'(rx_data), 32'h588);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule